// File: doc/BRIEF.md
# Two-Cycle Masked Ternary Match Table

The block holds a small table of ternary entries. Each entry is a 68-bit data word with its own 68-bit local mask. A search is a two-cycle command. In the first cycle, A, the caller presents the key and picks a pair of global mask registers. In the second cycle, B, the caller presents the same key again and picks a pair of comparand registers. The key is compared with every entry at once. A key bit takes part in the compare only when it is enabled in both the effective global mask and the entry's local mask. The lowest-numbered matching entry wins.

The winning address leaves through a fixed four-stage pipeline. The valid and found flags follow it after an extra programmable delay of 0 to 7 cycles. The key from cycle A is also stored into both registers of the selected comparand pair, and those registers can be read back. Entries and global mask registers are written through their own write ports. A search uses the table as it stood before the edge that samples cycle A. Searches are accepted at most once every two cycles.

Top module: `tcam_search_top`

## Requirements
- R1: A search starts when `srch_a` is high in a cycle that is not a B cycle. The cycle after it is always its B cycle, and `srch_a` is ignored during a B cycle. Holding `srch_a` high for four cycles therefore gives exactly two searches.
- R2: Key bit i is compared only when bit i is 1 in both the local mask of the entry and the effective global mask. The effective global mask is the bitwise AND of global mask register 2p (even) and register 2p+1 (odd), where p is `gm_pair_sel` in cycle A. A mask bit of 0 is don't-care.
- R3: When several entries match, the result is the lowest matching address.
- R4: Every accepted search produces exactly one `res_valid` pulse. When no entry matches, `res_found` is 0 during that pulse and `res_addr` becomes 0.
- R5: `res_addr` takes the search result at the 4th rising edge after the edge that samples cycle A. It holds that value until the next result arrives.
- R6: `res_valid` and `res_found` pulse for one cycle, starting at the (4 + `hold_lat`)th rising edge after the cycle-A edge. `res_found` is never high without `res_valid`.
- R7: At the cycle-B edge, the cycle-A key is written into comparand registers 2c and 2c+1, where c is `cmp_pair_sel` in cycle B. All other comparand registers are unchanged. `cmp_rd_data` shows register `cmp_rd_sel` combinationally.
- R8: If the key in cycle B differs from the key in cycle A, the search uses the cycle-A key and `key_err` rises. `key_err` then stays high until reset.
- R9: An entry write sampled on the cycle-A edge or later does not change that search's result. It does apply to later searches.
- R10: After reset, every entry holds data 0 with local mask all ones, every global mask register is all ones, every comparand register is 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_a | input | 1 | Search command, cycle A |
| srch_key | input | 68 | Search key (both cycles) |
| gm_pair_sel | input | 2 | Global mask pair, sampled in cycle A |
| cmp_pair_sel | input | 2 | Comparand pair, sampled in cycle B |
| ent_we | input | 1 | Entry write enable |
| ent_addr | input | 6 | Entry write address |
| ent_data | input | 68 | Entry data word |
| ent_mask | input | 68 | Entry local mask (1 = compare) |
| gm_we | input | 1 | Global mask register write enable |
| gm_wsel | input | 3 | Global mask register index |
| gm_wdata | input | 68 | Global mask value |
| hold_lat | input | 3 | Extra flag delay in cycles |
| cmp_rd_sel | input | 3 | Comparand register read index |
| cmp_rd_data | output | 68 | Comparand register contents |
| res_addr | output | 6 | Winning address |
| res_valid | output | 1 | Result valid pulse |
| res_found | output | 1 | Match found |
| key_err | output | 1 | Sticky cycle-B key mismatch |

## Verification
Two activities can meet in the same cycle: an entry write and the capture of a search. The bench drives an entry write on the same edge that samples cycle A, and on the cycle-B edge. It overwrites the very entry the key would hit and checks that the search still reports the old winner, while the next search sees the new contents. A second collision is between a new command and a B cycle: `srch_a` is held high through four cycles, and the bench counts exactly two result pulses at their expected edges.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned KEY_W_DEF = 68;
  localparam int unsigned DEPTH_DEF = 64;

  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
  parameter int unsigned KEY_W = 68,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [KEY_W-1:0] wdata,
  input  logic [KEY_W-1:0] wmask,
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] gmask,
  output logic [DEPTH-1:0] hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [KEY_W-1:0] data_q, data_n;
    logic [KEY_W-1:0] lmsk_q, lmsk_n;
    logic             wen;

    always_comb begin
      wen    = we && (waddr == AW'(i));
      data_n = data_q;
      lmsk_n = lmsk_q;
      if (wen) begin
        data_n = wdata;
        lmsk_n = wmask;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        lmsk_q <= '1;
      end else if (wen) begin
        data_q <= data_n;
        lmsk_q <= lmsk_n;
      end
    end

    assign hit[i] = ~|((key ^ data_q) & lmsk_q & gmask);
  end
endmodule

// File: rtl/tcam_first_hit.sv
module tcam_first_hit #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] hit,
  output logic             found,
  output logic [AW-1:0]    addr
);
  always_comb begin
    found = |hit;
    addr  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) addr = AW'(i);
    end
  end
endmodule

// File: rtl/tcam_flag_delay.sv
module tcam_flag_delay #(
  parameter int unsigned SW = 3,
  localparam int unsigned NT = 1 << SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_fnd,
  input  logic [SW-1:0] sel,
  output logic          out_vld,
  output logic          out_fnd
);
  logic [NT-1:0] vld_q, vld_n;
  logic [NT-1:0] fnd_q, fnd_n;

  always_comb begin
    vld_n = {vld_q[NT-2:0], in_vld};
    fnd_n = {fnd_q[NT-2:0], in_vld & in_fnd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      fnd_q <= '0;
    end else begin
      vld_q <= vld_n;
      fnd_q <= fnd_n;
    end
  end

  assign out_vld = vld_q[sel];
  assign out_fnd = fnd_q[sel];
endmodule

// File: rtl/tcam_search_top.sv
module tcam_search_top
  import tcam_pkg::*;
#(
  parameter int unsigned KEY_W     = KEY_W_DEF,
  parameter int unsigned DEPTH     = DEPTH_DEF,
  parameter int unsigned GM_PAIRS  = 4,
  parameter int unsigned CMP_PAIRS = 4,
  parameter int unsigned LAT_W     = 3,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned GP_W = $clog2(GM_PAIRS),
  localparam int unsigned GR_W = GP_W + 1,
  localparam int unsigned CP_W = $clog2(CMP_PAIRS),
  localparam int unsigned CR_W = CP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srch_a,
  input  logic [KEY_W-1:0] srch_key,
  input  logic [GP_W-1:0]  gm_pair_sel,
  input  logic [CP_W-1:0]  cmp_pair_sel,
  input  logic             ent_we,
  input  logic [AW-1:0]    ent_addr,
  input  logic [KEY_W-1:0] ent_data,
  input  logic [KEY_W-1:0] ent_mask,
  input  logic             gm_we,
  input  logic [GR_W-1:0]  gm_wsel,
  input  logic [KEY_W-1:0] gm_wdata,
  input  logic [LAT_W-1:0] hold_lat,
  input  logic [CR_W-1:0]  cmp_rd_sel,
  output logic [KEY_W-1:0] cmp_rd_data,
  output logic [AW-1:0]    res_addr,
  output logic             res_valid,
  output logic             res_found,
  output logic             key_err
);
  localparam int unsigned GM_REGS  = 2 * GM_PAIRS;
  localparam int unsigned CMP_REGS = 2 * CMP_PAIRS;

  // command phase
  phase_e ph_q, ph_n;
  logic   acc_a;
  logic   in_b;

  // global mask registers
  logic [KEY_W-1:0] gm_q [GM_REGS];
  logic [KEY_W-1:0] gm_n [GM_REGS];
  logic [KEY_W-1:0] gm_eff;

  // comparand registers
  logic [KEY_W-1:0] cmp_q [CMP_REGS];
  logic [KEY_W-1:0] cmp_n [CMP_REGS];
  logic             cmp_en;

  // pipeline
  logic [DEPTH-1:0] hit_vec, hit_q;
  logic [KEY_W-1:0] key_q;
  logic             s1_v;
  logic             enc_fnd;
  logic [AW-1:0]    enc_addr;
  logic             s2_v, s3_v, s4_v;
  logic             s2_f, s3_f, s4_f;
  logic [AW-1:0]    s2_a, s3_a, s4_a;
  logic [AW-1:0]    res_addr_n;
  logic             err_q, err_n;

  // ---------------- phase control ----------------
  assign in_b  = (ph_q == PH_B);
  assign acc_a = srch_a && !in_b;

  always_comb begin
    ph_n = acc_a ? PH_B : PH_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_A;
    else        ph_q <= ph_n;
  end

  // ---------------- global mask registers ----------------
  always_comb begin
    for (int r = 0; r < GM_REGS; r++) gm_n[r] = gm_q[r];
    if (gm_we) gm_n[gm_wsel] = gm_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < GM_REGS; r++) gm_q[r] <= '1;
    end else if (gm_we) begin
      for (int r = 0; r < GM_REGS; r++) gm_q[r] <= gm_n[r];
    end
  end

  assign gm_eff = gm_q[{gm_pair_sel, 1'b0}] & gm_q[{gm_pair_sel, 1'b1}];

  // ---------------- entry table and priority ----------------
  tcam_entry_store #(
    .KEY_W (KEY_W),
    .DEPTH (DEPTH)
  ) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ent_we),
    .waddr (ent_addr),
    .wdata (ent_data),
    .wmask (ent_mask),
    .key   (srch_key),
    .gmask (gm_eff),
    .hit   (hit_vec)
  );

  tcam_first_hit #(
    .DEPTH (DEPTH)
  ) prio_i (
    .hit   (hit_q),
    .found (enc_fnd),
    .addr  (enc_addr)
  );

  // stage 1: capture hits and key on the cycle-A edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= '0;
      key_q <= '0;
    end else if (acc_a) begin
      hit_q <= hit_vec;
      key_q <= srch_key;
    end
  end

  // stages 1..4 valid/result shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s3_v <= 1'b0;
      s4_v <= 1'b0;
      s2_f <= 1'b0;
      s3_f <= 1'b0;
      s4_f <= 1'b0;
      s2_a <= '0;
      s3_a <= '0;
      s4_a <= '0;
    end else begin
      s1_v <= acc_a;
      s2_v <= s1_v;
      s3_v <= s2_v;
      s4_v <= s3_v;
      if (s1_v) begin
        s2_f <= enc_fnd;
        s2_a <= enc_addr;
      end
      if (s2_v) begin
        s3_f <= s2_f;
        s3_a <= s2_a;
      end
      if (s3_v) begin
        s4_f <= s3_f;
        s4_a <= s3_a;
      end
    end
  end

  // output address register
  always_comb begin
    res_addr_n = s4_f ? s4_a : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_addr <= '0;
    else if (s4_v) res_addr <= res_addr_n;
  end

  tcam_flag_delay #(
    .SW (LAT_W)
  ) flags_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (s4_v),
    .in_fnd  (s4_f),
    .sel     (hold_lat),
    .out_vld (res_valid),
    .out_fnd (res_found)
  );

  // ---------------- cycle B: comparand store and key check ----------------
  assign cmp_en = in_b;

  always_comb begin
    for (int r = 0; r < CMP_REGS; r++) cmp_n[r] = cmp_q[r];
    cmp_n[{cmp_pair_sel, 1'b0}] = key_q;
    cmp_n[{cmp_pair_sel, 1'b1}] = key_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < CMP_REGS; r++) cmp_q[r] <= '0;
    end else if (cmp_en) begin
      for (int r = 0; r < CMP_REGS; r++) cmp_q[r] <= cmp_n[r];
    end
  end

  assign cmp_rd_data = cmp_q[cmp_rd_sel];

  always_comb begin
    err_n = err_q | (in_b && (srch_key != key_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  assign key_err = err_q;
endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk #(
  parameter int unsigned AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_a,
  input logic          s4_v,
  input logic          res_valid,
  input logic          res_found,
  input logic          key_err,
  input logic [AW-1:0] res_addr
);
  logic [4:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_q + 5'(acc_a) - 5'(res_valid);
  end

  assert_found_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_found |-> res_valid);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_err |=> key_err);

  assert_one_result_per_search_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (pend_q != 5'd0));

  assert_pending_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= 5'd8);

  assert_addr_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !s4_v |=> $stable(res_addr));
endmodule

bind tcam_search_top tcam_search_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_a     (acc_a),
  .s4_v      (s4_v),
  .res_valid (res_valid),
  .res_found (res_found),
  .key_err   (key_err),
  .res_addr  (res_addr)
);

// File: tb/tcam_search_top_tb.sv
module tcam_search_top_tb_top;
  localparam int CLK_P = 10;
  localparam int KW    = 68;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          srch_a = 1'b0;
  logic [KW-1:0] srch_key = '0;
  logic [1:0]    gm_pair_sel = '0;
  logic [1:0]    cmp_pair_sel = '0;
  logic          ent_we = 1'b0;
  logic [5:0]    ent_addr = '0;
  logic [KW-1:0] ent_data = '0;
  logic [KW-1:0] ent_mask = '0;
  logic          gm_we = 1'b0;
  logic [2:0]    gm_wsel = '0;
  logic [KW-1:0] gm_wdata = '0;
  logic [2:0]    hold_lat = '0;
  logic [2:0]    cmp_rd_sel = '0;
  logic [KW-1:0] cmp_rd_data;
  logic [5:0]    res_addr;
  logic          res_valid, res_found, key_err;

  int n_chk = 0;
  int n_bad = 0;

  logic [KW-1:0] m_d [64];
  logic [KW-1:0] m_m [64];
  logic [KW-1:0] m_g [8];
  logic [KW-1:0] m_c [8];

  always #(CLK_P/2) clk = ~clk;

  tcam_search_top dut_i (
    .clk(clk), .rst_n(rst_n), .srch_a(srch_a), .srch_key(srch_key),
    .gm_pair_sel(gm_pair_sel), .cmp_pair_sel(cmp_pair_sel),
    .ent_we(ent_we), .ent_addr(ent_addr), .ent_data(ent_data), .ent_mask(ent_mask),
    .gm_we(gm_we), .gm_wsel(gm_wsel), .gm_wdata(gm_wdata), .hold_lat(hold_lat),
    .cmp_rd_sel(cmp_rd_sel), .cmp_rd_data(cmp_rd_data), .res_addr(res_addr),
    .res_valid(res_valid), .res_found(res_found), .key_err(key_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [KW-1:0] act, input logic [KW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_srch(input logic [KW-1:0] key, input int gp,
                                     output bit fnd, output int adr);
    logic [KW-1:0] g;
    g = m_g[2*gp] & m_g[2*gp+1];
    fnd = 1'b0;
    adr = 0;
    for (int i = 0; i < 64; i++) begin
      if (!fnd && (((key ^ m_d[i]) & m_m[i] & g) == '0)) begin
        fnd = 1'b1;
        adr = i;
      end
    end
  endfunction

  task automatic wr_entry(input int a, input logic [KW-1:0] d, input logic [KW-1:0] m);
    @(negedge clk);
    ent_we = 1'b1; ent_addr = 6'(a); ent_data = d; ent_mask = m;
    @(negedge clk);
    ent_we = 1'b0;
    m_d[a] = d; m_m[a] = m;
  endtask

  task automatic wr_gm(input int s, input logic [KW-1:0] v);
    @(negedge clk);
    gm_we = 1'b1; gm_wsel = 3'(s); gm_wdata = v;
    @(negedge clk);
    gm_we = 1'b0;
    m_g[s] = v;
  endtask

  // wph: 0 none, 1 write in cycle A, 2 write in cycle B
  task automatic do_search(input logic [KW-1:0] key, input logic [KW-1:0] keyb,
                           input int gp, input int cp, input int lat,
                           input int wph, input int wa, input logic [KW-1:0] wd,
                           input string req);
    bit e_f; int e_a; int nv; int vj; bit vf; logic [5:0] a4;
    model_srch(key, gp, e_f, e_a);
    @(negedge clk);
    hold_lat = 3'(lat);
    srch_a = 1'b1; srch_key = key; gm_pair_sel = 2'(gp);
    if (wph == 1) begin
      ent_we = 1'b1; ent_addr = 6'(wa); ent_data = wd; ent_mask = '1;
    end
    @(negedge clk);
    srch_a = 1'b0; srch_key = keyb; cmp_pair_sel = 2'(cp);
    ent_we = 1'b0;
    if (wph == 1) begin m_d[wa] = wd; m_m[wa] = '1; end
    if (wph == 2) begin
      ent_we = 1'b1; ent_addr = 6'(wa); ent_data = wd; ent_mask = '1;
    end
    @(negedge clk);
    ent_we = 1'b0;
    if (wph == 2) begin m_d[wa] = wd; m_m[wa] = '1; end
    m_c[2*cp] = key; m_c[2*cp+1] = key;
    nv = 0; vj = -1; vf = 1'b0; a4 = '0;
    for (int j = 1; j <= 14; j++) begin
      if (j > 1) @(negedge clk);
      if (j == 4) a4 = res_addr;
      if (res_valid) begin
        nv++;
        if (vj < 0) begin vj = j; vf = res_found; end
      end
    end
    chk(a4 == 6'(e_f ? e_a : 0), {req, " R5"}, "addr at edge 4", KW'(a4), KW'(e_f ? e_a : 0));
    chk(nv == 1, {req, " R4"}, "valid pulse count", KW'(nv), KW'(1));
    chk(vj == 4 + lat, {req, " R6"}, "valid edge", KW'(vj), KW'(4 + lat));
    chk(vf == e_f, {req, " R6"}, "found flag", KW'(vf), KW'(e_f));
  endtask

  function automatic logic [KW-1:0] pat(input int i);
    return {4'(i % 16), 32'(i * 13 + 7), 26'(~i), 6'(i)};
  endfunction

  // watchdog
  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit f; int a;
    for (int i = 0; i < 64; i++) begin m_d[i] = '0; m_m[i] = '1; end
    for (int i = 0; i < 8; i++) begin m_g[i] = '1; m_c[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk(res_valid == 0 && res_found == 0, "R10", "flags after reset", KW'({res_valid, res_found}), '0);
    chk(res_addr == 0, "R10", "addr after reset", KW'(res_addr), '0);
    chk(key_err == 0, "R10", "key_err after reset", KW'(key_err), '0);
    for (int r = 0; r < 8; r++) begin
      cmp_rd_sel = 3'(r); #1;
      chk(cmp_rd_data == '0, "R10", "comparand reset", cmp_rd_data, '0);
    end
    // R10: reset table matches key 0 at entry 0; nonzero key misses
    do_search('0, '0, 0, 0, 0, 0, 0, '0, "R10 reset table");
    do_search(68'h5, 68'h5, 0, 0, 0, 0, 0, '0, "R10 reset miss");

    // fill table
    for (int i = 0; i < 64; i++) wr_entry(i, pat(i), '1);

    // R2/R3/R6: sweep every entry, latency sweep across 0..7
    for (int i = 0; i < 64; i++) begin
      do_search(pat(i), pat(i), 0, i % 4, i % 8, 0, 0, '0, "R2 sweep");
      model_srch(pat(i), 0, f, a);
      chk(f && a == i, "R2", "model sanity", KW'(a), KW'(i));
    end

    // R4: miss drives address to zero
    do_search(68'h5_5555_5555_5555_5555, 68'h5_5555_5555_5555_5555, 0, 0, 3, 0, 0, '0, "R4 miss");

    // R2: local mask don't-care bits
    wr_entry(50, pat(50), {60'hFFF_FFFF_FFFF_FFFF, 8'h00});
    do_search(pat(50) ^ 68'hA5, pat(50) ^ 68'hA5, 0, 1, 1, 0, 0, '0, "R2 local mask");
    // R3: two matches, lowest wins
    wr_entry(20, pat(50), {60'hFFF_FFFF_FFFF_FFFF, 8'h00});
    do_search(pat(50) ^ 68'h3C, pat(50) ^ 68'h3C, 0, 1, 2, 0, 0, '0, "R3 priority");
    model_srch(pat(50) ^ 68'h3C, 0, f, a);
    chk(a == 20, "R3", "lowest of 20/50", KW'(a), KW'(20));

    // R2: global mask pair AND of even and odd
    wr_gm(2, {4'h0, 64'hFFFF_FFFF_FFFF_FFFF});
    do_search(pat(9) ^ {4'hF, 64'h0}, pat(9) ^ {4'hF, 64'h0}, 1, 0, 0, 0, 0, '0, "R2 gm even");
    do_search(pat(9) ^ {4'hF, 64'h0}, pat(9) ^ {4'hF, 64'h0}, 0, 0, 0, 0, 0, '0, "R2 gm pair0 miss");
    wr_gm(5, {36'hF_FFFF_FFFF, 32'h0});
    do_search(pat(11) ^ 68'h1234_0000, pat(11) ^ 68'h1234_0000, 2, 0, 0, 0, 0, '0, "R2 gm odd");

    // R9: write on cycle-A edge and on cycle-B edge do not affect this search
    do_search(pat(7), pat(7), 0, 0, 0, 1, 7, 68'hABC, "R9 write in A");
    do_search(pat(7), pat(7), 0, 0, 0, 0, 0, '0, "R9 after write A");
    do_search(pat(8), pat(8), 0, 0, 0, 2, 8, 68'hDEF, "R9 write in B");
    do_search(pat(8), pat(8), 0, 0, 0, 0, 0, '0, "R9 after write B");

    // R7: comparand pair storage
    do_search(pat(33), pat(33), 0, 2, 0, 0, 0, '0, "R7 store");
    for (int r = 0; r < 8; r++) begin
      cmp_rd_sel = 3'(r); #1;
      chk(cmp_rd_data == m_c[r], "R7", "comparand readback", cmp_rd_data, m_c[r]);
    end

    // R8: cycle-B key mismatch
    chk(key_err == 0, "R8", "no error yet", KW'(key_err), '0);
    do_search(pat(3), pat(4), 0, 3, 0, 0, 0, '0, "R8 uses key A");
    chk(key_err == 1, "R8", "error raised", KW'(key_err), KW'(1));
    cmp_rd_sel = 3'd7; #1;
    chk(cmp_rd_data == pat(3), "R8", "comparand gets key A", cmp_rd_data, pat(3));
    do_search(pat(5), pat(5), 0, 0, 0, 0, 0, '0, "R8 later search");
    chk(key_err == 1, "R8", "error sticky", KW'(key_err), KW'(1));

    // R1: srch_a held for four cycles -> two searches at edges 0 and 2
    begin
      int nv; int v4; int v6; logic [5:0] a4; logic [5:0] a6;
      @(negedge clk);
      hold_lat = 3'd0;
      srch_a = 1'b1; srch_key = pat(12); gm_pair_sel = 2'd0; cmp_pair_sel = 2'd0;
      @(negedge clk); srch_key = pat(12);
      @(negedge clk); srch_key = pat(40);
      @(negedge clk); srch_key = pat(40);
      @(negedge clk); srch_a = 1'b0;
      // now after edge 3
      nv = 0; v4 = 0; v6 = 0; a4 = '0; a6 = '0;
      for (int j = 4; j <= 14; j++) begin
        @(negedge clk);
        if (res_valid) nv++;
        if (j == 4) begin v4 = int'(res_valid && res_found); a4 = res_addr; end
        if (j == 6) begin v6 = int'(res_valid && res_found); a6 = res_addr; end
      end
      chk(nv == 2, "R1", "two searches from held command", KW'(nv), KW'(2));
      chk(v4 == 1 && a4 == 12, "R1", "first result", KW'(a4), KW'(12));
      chk(v6 == 1 && a6 == 40, "R1", "second result", KW'(a6), KW'(40));
    end

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule